// File: doc/BRIEF.md
# Bandwidth Usage Monitor Counter

This block counts memory traffic for one partition. It watches a stream of transfer beats. Each beat carries a partition identifier and a byte count. While monitoring is switched on, the byte count of every beat whose identifier equals the programmed filter value is added to an internal counter. Software reaches the block through a 32-bit register port with four word registers: control, filter, counter low word and counter high word. Counter widths of 31, 44 or 63 bits are chosen at build time.

The top bit of the 64-bit counter view is a not-ready flag. Any control write that leaves monitoring switched on raises this flag, even when the written value equals the old one. Only software can drop it, by writing the high counter word with its top bit clear. For this reason the configuration order matters: write the control register first, then zero the counter. Clearing the enable bit freezes the count. When the count wraps, a sticky overflow status bit is set in the control register.

The enable bit and the not-ready flag are held in a four-state machine:
- `ST_IDLE`: disabled, flag clear.
- `ST_IDLE_NRDY`: disabled, flag set.
- `ST_RUN`: counting, flag clear.
- `ST_RUN_NRDY`: counting, flag set.

The transitions are:
- A control write with enable set goes from any state to `ST_RUN_NRDY`.
- A control write with enable clear goes to `ST_IDLE` or `ST_IDLE_NRDY` and keeps the flag as it was.
- A high-word write with bit 31 clear moves `ST_RUN_NRDY` to `ST_RUN` and `ST_IDLE_NRDY` to `ST_IDLE`.
- Every other cycle holds the state.

Top module: `bwmon_counter`

## Requirements
- R1: After reset, all four registers read zero: control (byte offset 0x0), filter (0x4), counter low word (0x8) and counter high word (0xC).
- R2: A control write with bit 31 (enable) set makes bit 31 of the counter high word read 1 on the next cycle, also when enable was already set.
- R3: The not-ready flag stays set through low-word writes, high-word writes with bit 31 set and control writes with enable clear. It clears after a high-word write with bit 31 clear.
- R4: While enabled, a valid beat whose partition ID equals the filter adds its byte count to the counter by the next cycle. A beat with any other ID adds nothing.
- R5: While disabled, beats leave the count unchanged, and repeated reads return the same value.
- R6: A write to one counter word replaces only that word's count bits. Count bits at or above the configured width read zero. A high-word write never sets the not-ready flag.
- R7: When the count passes 2^width it continues modulo 2^width. For widths above 32 this sets control bit 2 (long overflow). Otherwise it sets control bit 1 (overflow).
- R8: Each overflow status bit clears when written as 0. Writing it as 1 does not change it.
- R9: When a counter write and a matching beat fall in the same cycle, the written value is kept and the beat is dropped.
- R10: The filter register holds the partition ID in its low bits and reads it back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write byte offset (word aligned) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read byte offset (word aligned) |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| beat_valid | input | 1 | Traffic beat present |
| beat_pid | input | PID_W | Partition ID of the beat |
| beat_bytes | input | BYTES_W | Bytes moved by the beat |

## Verification
The wrap of a 44-bit count is the case that is hardest to reach from the ports. Real traffic would need about 2^44 bytes to get there. The stimulus instead loads the counter just below the limit through the two word writes. It then enables monitoring and sends one beat that crosses the limit. The bench also drives a counter write and a matching beat in the same cycle to exercise the priority rule. A second instance built with a 31-bit counter exercises the other overflow bit.

// File: rtl/bwmon_pkg.sv
package bwmon_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'b00,
        ST_IDLE_NRDY = 2'b01,
        ST_RUN       = 2'b10,
        ST_RUN_NRDY  = 2'b11
    } mon_state_e;

    localparam logic [1:0] REG_CTRL   = 2'd0;
    localparam logic [1:0] REG_FILT   = 2'd1;
    localparam logic [1:0] REG_CNT_LO = 2'd2;
    localparam logic [1:0] REG_CNT_HI = 2'd3;

    localparam int CTRL_EN_BIT   = 31;
    localparam int CTRL_OVF_BIT  = 1;
    localparam int CTRL_OVFL_BIT = 2;
    localparam int HI_NRDY_BIT   = 31;
endpackage

// File: rtl/bwmon_ctrl_fsm.sv
module bwmon_ctrl_fsm
    import bwmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_en_val,
    input  logic hi_wr,
    input  logic hi_top_bit,
    output logic en,
    output logic nrdy
);
    mon_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_wr && ctrl_en_val) state_d = ST_RUN_NRDY;
            end
            ST_IDLE_NRDY: begin
                if (ctrl_wr && ctrl_en_val)    state_d = ST_RUN_NRDY;
                else if (hi_wr && !hi_top_bit) state_d = ST_IDLE;
            end
            ST_RUN: begin
                if (ctrl_wr) state_d = ctrl_en_val ? ST_RUN_NRDY : ST_IDLE;
            end
            ST_RUN_NRDY: begin
                if (ctrl_wr)                   state_d = ctrl_en_val ? ST_RUN_NRDY : ST_IDLE_NRDY;
                else if (hi_wr && !hi_top_bit) state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        en   = 1'b0;
        nrdy = 1'b0;
        unique case (state_q)
            ST_IDLE:      begin en = 1'b0; nrdy = 1'b0; end
            ST_IDLE_NRDY: begin en = 1'b0; nrdy = 1'b1; end
            ST_RUN:       begin en = 1'b1; nrdy = 1'b0; end
            ST_RUN_NRDY:  begin en = 1'b1; nrdy = 1'b1; end
            default:      begin en = 1'b0; nrdy = 1'b0; end
        endcase
    end
endmodule

// File: rtl/bwmon_accum.sv
module bwmon_accum #(
    parameter int CNT_W   = 44,
    parameter int BYTES_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               beat_hit,
    input  logic [BYTES_W-1:0] beat_bytes,
    input  logic               lo_wr,
    input  logic               hi_wr,
    input  logic [31:0]        wdata,
    output logic [CNT_W-1:0]   cnt,
    output logic               wrap
);
    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [63:0]      view;
    logic [SUM_W-1:0] sum;
    logic             sw_wr;
    logic             add;
    logic             unused_view;

    assign sw_wr = lo_wr | hi_wr;
    assign add   = en & beat_hit & ~sw_wr;
    assign sum   = {1'b0, cnt_q} + SUM_W'(beat_bytes);

    // Merge a half-word write into the current count
    always_comb begin
        view              = '0;
        view[CNT_W-1:0]   = cnt_q;
        if (lo_wr) view[31:0]  = wdata;
        if (hi_wr) view[63:32] = wdata;
    end
    assign unused_view = ^view[63:CNT_W];

    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (sw_wr) cnt_q <= view[CNT_W-1:0];
        else if (add)   cnt_q <= sum[CNT_W-1:0];
    end

    assign cnt  = cnt_q;
    assign wrap = add & sum[CNT_W];
endmodule

// File: rtl/bwmon_counter.sv
module bwmon_counter
    import bwmon_pkg::*;
#(
    parameter int CNT_W   = 44,
    parameter int PID_W   = 8,
    parameter int BYTES_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [3:0]         wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [3:0]         rd_addr,
    output logic [31:0]        rd_data,
    input  logic               beat_valid,
    input  logic [PID_W-1:0]   beat_pid,
    input  logic [BYTES_W-1:0] beat_bytes
);
    logic             ctrl_wr, filt_wr, lo_wr, hi_wr;
    logic             en, nrdy, wrap, wrap_g, wrap_l, beat_hit;
    logic             ovf_g_q, ovf_l_q;
    logic [PID_W-1:0] filt_q;
    logic [CNT_W-1:0] cnt;
    logic [63:0]      cnt64;
    logic             unused_addr;

    assign ctrl_wr     = wr_en && wr_addr[3:2] == REG_CTRL;
    assign filt_wr     = wr_en && wr_addr[3:2] == REG_FILT;
    assign lo_wr       = wr_en && wr_addr[3:2] == REG_CNT_LO;
    assign hi_wr       = wr_en && wr_addr[3:2] == REG_CNT_HI;
    assign unused_addr = ^{wr_addr[1:0], rd_addr[1:0]};
    assign beat_hit    = beat_valid && beat_pid == filt_q;

    bwmon_ctrl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .ctrl_en_val(wr_data[CTRL_EN_BIT]),
        .hi_wr(hi_wr), .hi_top_bit(wr_data[HI_NRDY_BIT]),
        .en(en), .nrdy(nrdy)
    );

    bwmon_accum #(.CNT_W(CNT_W), .BYTES_W(BYTES_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .en(en), .beat_hit(beat_hit),
        .beat_bytes(beat_bytes), .lo_wr(lo_wr), .hi_wr(hi_wr),
        .wdata(wr_data), .cnt(cnt), .wrap(wrap)
    );

    // The counter width picks which status bit a wrap sets
    generate
        if (CNT_W > 32) begin : g_long
            assign wrap_l = wrap;
            assign wrap_g = 1'b0;
        end else begin : g_short
            assign wrap_l = 1'b0;
            assign wrap_g = wrap;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_g_q <= 1'b0;
            ovf_l_q <= 1'b0;
            filt_q  <= '0;
        end else begin
            ovf_g_q <= (ctrl_wr ? ovf_g_q & wr_data[CTRL_OVF_BIT]  : ovf_g_q) | wrap_g;
            ovf_l_q <= (ctrl_wr ? ovf_l_q & wr_data[CTRL_OVFL_BIT] : ovf_l_q) | wrap_l;
            if (filt_wr) filt_q <= wr_data[PID_W-1:0];
        end
    end

    always_comb begin
        cnt64            = '0;
        cnt64[CNT_W-1:0] = cnt;
        cnt64[63]        = nrdy;
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr[3:2])
            REG_CTRL:   rd_data = {en, 28'd0, ovf_l_q, ovf_g_q, 1'b0};
            REG_FILT:   rd_data = 32'(filt_q);
            REG_CNT_LO: rd_data = cnt64[31:0];
            REG_CNT_HI: rd_data = cnt64[63:32];
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/bwmon_checker.sv
module bwmon_checker #(
    parameter int CNT_W = 44,
    parameter int PID_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [3:0]       wr_addr,
    input logic [31:0]      wr_data,
    input logic             beat_valid,
    input logic [PID_W-1:0] beat_pid,
    input logic [PID_W-1:0] filt_q,
    input logic             en,
    input logic             nrdy,
    input logic [CNT_W-1:0] cnt,
    input logic             ovf_l_q
);
    logic ctrl_w, cnt_w, hi_clr, hit;
    assign ctrl_w = wr_en && wr_addr[3:2] == 2'd0;
    assign cnt_w  = wr_en && wr_addr[3] == 1'b1;
    assign hi_clr = wr_en && wr_addr[3:2] == 2'd3 && !wr_data[31];
    assign hit    = beat_valid && beat_pid == filt_q;

    AST_EN_RAISES_NRDY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_w && wr_data[31]) |=> nrdy); // R2
    AST_NRDY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (nrdy && !hi_clr) |=> nrdy); // R3
    AST_NO_MISS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !hit && !cnt_w) |=> $stable(cnt)); // R4
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_w) |=> $stable(cnt)); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_l_q && !(ctrl_w && !wr_data[2])) |=> ovf_l_q); // R8
endmodule

bind bwmon_counter bwmon_checker #(.CNT_W(CNT_W), .PID_W(PID_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .beat_valid(beat_valid), .beat_pid(beat_pid),
    .filt_q(filt_q), .en(en), .nrdy(nrdy), .cnt(cnt), .ovf_l_q(ovf_l_q)
);

// File: tb/tb_bwmon_counter.sv
module tb_bwmon_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic        wr_en0 = 0, wr_en1 = 0, bv0 = 0, bv1 = 0;
    logic [3:0]  wa0 = '0, wa1 = '0;
    logic [31:0] wd0 = '0, wd1 = '0, rdd0, rdd1;
    logic [7:0]  pid0 = '0, pid1 = '0, by0 = '0, by1 = '0;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bwmon_counter dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en0), .wr_addr(wa0),
        .wr_data(wd0), .rd_addr(rd_addr), .rd_data(rdd0), .beat_valid(bv0),
        .beat_pid(pid0), .beat_bytes(by0));
    bwmon_counter #(.CNT_W(31)) dut31 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en1),
        .wr_addr(wa1), .wr_data(wd1), .rd_addr(rd_addr), .rd_data(rdd1),
        .beat_valid(bv1), .beat_pid(pid1), .beat_bytes(by1));

    typedef struct {int d; logic [3:0] a; logic [31:0] exp; string tag;} item_t;
    item_t sb[$];

    // Monitor: pops expected items and compares with the read port
    initial forever begin
        @(negedge clk);
        if (sb.size() > 0) begin
            item_t it;
            logic [31:0] got;
            it = sb[0];
            rd_addr = it.a;
            #1;
            got = (it.d == 0) ? rdd0 : rdd1;
            checks++;
            if (got !== it.exp) begin
                fails++;
                $display("FAIL %s: addr 0x%0h actual 0x%08h expected 0x%08h", it.tag, it.a, got, it.exp);
            end
            void'(sb.pop_front());
        end
    end

    task automatic expect_rd(int d, logic [3:0] a, logic [31:0] e, string tag);
        item_t it;
        it.d = d; it.a = a; it.exp = e; it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic wr(int d, logic [3:0] a, logic [31:0] v);
        @(negedge clk);
        if (d == 0) begin wr_en0 = 1; wa0 = a; wd0 = v; end
        else        begin wr_en1 = 1; wa1 = a; wd1 = v; end
        @(negedge clk);
        wr_en0 = 0; wr_en1 = 0;
    endtask

    task automatic beat(int d, logic [7:0] p, logic [7:0] b);
        @(negedge clk);
        if (d == 0) begin bv0 = 1; pid0 = p; by0 = b; end
        else        begin bv1 = 1; pid1 = p; by1 = b; end
        @(negedge clk);
        bv0 = 0; bv1 = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        expect_rd(0, 4'h0, 32'h0, "R1 ctrl");
        expect_rd(0, 4'h4, 32'h0, "R1 filt");
        expect_rd(0, 4'h8, 32'h0, "R1 lo");
        expect_rd(0, 4'hC, 32'h0, "R1 hi");
        wr(0, 4'h4, 32'h05);
        expect_rd(0, 4'h4, 32'h05, "R10 filter");
        wr(0, 4'h0, 32'h8000_0000);
        expect_rd(0, 4'hC, 32'h8000_0000, "R2 enable sets nrdy");
        expect_rd(0, 4'h0, 32'h8000_0000, "R2 ctrl");
        beat(0, 8'h05, 8'h10);
        expect_rd(0, 4'h8, 32'h10, "R4 matching beat");
        beat(0, 8'h03, 8'h40);
        expect_rd(0, 4'h8, 32'h10, "R4 other pid ignored");
        wr(0, 4'h8, 32'h0);
        expect_rd(0, 4'hC, 32'h8000_0000, "R3 lo write keeps nrdy");
        wr(0, 4'hC, 32'h8000_0000);
        expect_rd(0, 4'hC, 32'h8000_0000, "R3 hi bit31 set keeps nrdy");
        wr(0, 4'hC, 32'h0);
        expect_rd(0, 4'hC, 32'h0, "R3 hi zero clears nrdy");
        expect_rd(0, 4'h8, 32'h0, "R6 hi write keeps lo");
        wr(0, 4'h0, 32'h8000_0000);
        expect_rd(0, 4'hC, 32'h8000_0000, "R2 rewrite same value");
        wr(0, 4'hC, 32'h0);
        beat(0, 8'h05, 8'h22);
        expect_rd(0, 4'h8, 32'h22, "R4 count after clear");
        wr(0, 4'h0, 32'h0);
        expect_rd(0, 4'hC, 32'h0, "R3 disable leaves flag clear");
        beat(0, 8'h05, 8'h33);
        expect_rd(0, 4'h8, 32'h22, "R5 frozen first read");
        expect_rd(0, 4'h8, 32'h22, "R5 frozen second read");
        wr(0, 4'h8, 32'hFFFF_FFF0);
        wr(0, 4'hC, 32'hFFFF_FFFF);
        expect_rd(0, 4'hC, 32'h0000_0FFF, "R6 hi bits above width");
        expect_rd(0, 4'h8, 32'hFFFF_FFF0, "R6 lo preserved");
        wr(0, 4'h0, 32'h8000_0000);
        beat(0, 8'h05, 8'h20);
        expect_rd(0, 4'h8, 32'h10, "R7 wrap low word");
        expect_rd(0, 4'hC, 32'h8000_0000, "R7 wrap high word");
        expect_rd(0, 4'h0, 32'h8000_0004, "R7 long overflow bit");
        wr(0, 4'h0, 32'h8000_0006);
        expect_rd(0, 4'h0, 32'h8000_0004, "R8 write one keeps");
        wr(0, 4'h0, 32'h8000_0000);
        expect_rd(0, 4'h0, 32'h8000_0000, "R8 write zero clears");
        wr(0, 4'hC, 32'h0);
        @(negedge clk);
        wr_en0 = 1; wa0 = 4'h8; wd0 = 32'h100; bv0 = 1; pid0 = 8'h05; by0 = 8'h44;
        @(negedge clk);
        wr_en0 = 0; bv0 = 0;
        expect_rd(0, 4'h8, 32'h100, "R9 write beats accumulate");
        wr(1, 4'h8, 32'h7FFF_FFF0);
        wr(1, 4'h0, 32'h8000_0000);
        beat(1, 8'h00, 8'h20);
        expect_rd(1, 4'h8, 32'h10, "R7 short wrap");
        expect_rd(1, 4'h0, 32'h8000_0002, "R7 short overflow bit");
        expect_rd(1, 4'hC, 32'h8000_0000, "R2 short nrdy");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule